// File: doc/BRIEF.md
# Command Ring Consumer

This block is the consuming side of a command ring that software builds in memory. Software sets up a ring base and then moves a write offset forward as it adds 32-byte entries. While the ring is enabled and the two offsets differ, the block reads the entry at its read offset as four 64-bit words through a simple memory read port. It splits out the operand fields and offers the decoded command downstream on a valid/ready handshake.

The read offset moves forward by one entry only after the downstream side takes the command. Software can therefore poll the read offset and treat an entry as finished once the offset has passed it. Entries that carry an opcode the block does not support are flagged for one cycle and skipped. The ring holds 2048 entries in 64 KiB, and both offsets wrap to zero after the last entry. Software keeps one slot free, so equal offsets always mean the ring is empty.

Top module: `cmdq_engine`

## Requirements
- R1: After reset the ring base register, write offset and read offset all read as zero. No memory request, decoded command or error is presented.
- R2: Register reads are combinational on `reg_addr`:
  - Address 0x80 is the ring base. Bit 63 is the enable bit and bits [47:16] are the 64 KiB-aligned ring address. All other bits read as zero.
  - Address 0x88 is the write offset. It is written from bits [15:5] and reads back with bits [4:0] zero.
  - Address 0x90 is the read offset, which software cannot write.
  - Any other address reads as zero.
- R3: A write to the write offset while the enable bit is clear has no effect.
- R4: To fetch an entry, the block issues four reads in word order. Word w of entry i is read at address {ring[47:16], i[10:0], w[1:0], 3'b000}. Each read holds its address until `mem_rvalid`. Data lanes are little-endian: the byte at the lowest address sits in bits [7:0].
- R5: The decoded fields are taken as follows:
  - From word 0: opcode from bits [7:0] and device ID from bits [63:32].
  - From word 1: event ID from bits [31:0], physical ID from bits [63:32] and ID-bit count from bits [4:0].
  - From word 2: table address from bits [47:8], presented with bits [7:0] zero; map-valid flag from bit 63; target from bits [47:16], presented with bits [15:0] zero; collection ID from bits [15:0].
- R6: `cmd_valid` stays high with stable fields until `cmd_ready`. The read offset advances by 32 only on the cycle the command is accepted, and not before.
- R7: The supported opcodes are 0x01, 0x03, 0x04, 0x05, 0x08, 0x09, 0x0A, 0x0C, 0x0D, 0x0E and 0x0F. For any other opcode, `cmd_err` pulses for one cycle, `cmd_valid` stays low, and the read offset advances past the entry.
- R8: After the entry at offset 0xFFE0, the read offset returns to 0x0000.
- R9: While the enable bit is clear, no new fetch starts. A command already presented still completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 48 | Memory byte address |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 64 | Read data word |
| cmd_valid | output | 1 | Decoded command valid |
| cmd_ready | input | 1 | Downstream accepts command |
| cmd_err | output | 1 | One-cycle pulse for an unsupported opcode |
| cmd_opcode | output | 8 | Opcode |
| cmd_dev_id | output | 32 | Device ID |
| cmd_event_id | output | 32 | Event ID |
| cmd_phys_id | output | 32 | Physical interrupt ID |
| cmd_id_bits | output | 5 | ID bit count minus one |
| cmd_table_addr | output | 48 | Table address, 256-byte aligned |
| cmd_map_valid | output | 1 | Mapping valid flag |
| cmd_target | output | 48 | Target address, 64 KiB aligned |
| cmd_coll_id | output | 16 | Collection ID |

## Verification
The wrap from the last entry back to offset zero is the hardest case to reach. Software cannot set the read offset, so the only way there is to consume 2047 entries. The stimulus fills the small modelled memory, which aliases every 16 entries, with supported opcodes. It moves the write offset straight to 0xFFE0 with the handshake held ready, polls the read offset until it gets there, and then writes 0x0000 so that exactly one more entry is consumed. Pausing the ring while a command is still held is reached by holding `cmd_ready` low across the write that clears the enable bit.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam logic [7:0] REG_QBASE = 8'h80;
    localparam logic [7:0] REG_WOFF  = 8'h88;
    localparam logic [7:0] REG_ROFF  = 8'h90;

    // Number of leading entry words that carry operands
    localparam int KEEP_WORDS = 3;

    typedef enum logic [7:0] {
        OP_MOVE    = 8'h01,
        OP_INT     = 8'h03,
        OP_CLEAR   = 8'h04,
        OP_SYNC    = 8'h05,
        OP_MAPDEV  = 8'h08,
        OP_MAPCOL  = 8'h09,
        OP_MAPVID  = 8'h0A,
        OP_INV     = 8'h0C,
        OP_INVALL  = 8'h0D,
        OP_MOVALL  = 8'h0E,
        OP_DISCARD = 8'h0F
    } cmd_op_e;

    typedef struct packed {
        logic [7:0]  opcode;
        logic [31:0] dev_id;
        logic [31:0] event_id;
        logic [31:0] phys_id;
        logic [4:0]  id_bits;
        logic [47:0] table_addr;
        logic        map_valid;
        logic [47:0] target;
        logic [15:0] coll_id;
    } cmd_fields_t;

    function automatic logic op_known(input logic [7:0] op);
        case (op)
            OP_MOVE, OP_INT, OP_CLEAR, OP_SYNC, OP_MAPDEV, OP_MAPCOL,
            OP_MAPVID, OP_INV, OP_INVALL, OP_MOVALL, OP_DISCARD:
                return 1'b1;
            default:
                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [7:0]                reg_addr,
    input  logic [63:0]               reg_wdata,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic                      base_valid,
    output logic [ADDR_W-OFF_W-1:0]   ring_base,
    output logic [IDX_W-1:0]          wr_idx,
    output logic [63:0]               reg_rdata
);
    localparam int SHIFT  = OFF_W - IDX_W;
    localparam int BASE_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic              vld;
        logic [BASE_W-1:0] base;
        logic [IDX_W-1:0]  widx;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_addr)
                REG_QBASE: begin
                    r_d.vld  = reg_wdata[63];
                    r_d.base = reg_wdata[ADDR_W-1:OFF_W];
                end
                REG_WOFF: begin
                    if (r_q.vld) r_d.widx = reg_wdata[OFF_W-1:SHIFT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            REG_QBASE: reg_rdata = {r_q.vld, {(63-ADDR_W){1'b0}}, r_q.base, {OFF_W{1'b0}}};
            REG_WOFF:  reg_rdata = {{(64-OFF_W){1'b0}}, r_q.widx, {SHIFT{1'b0}}};
            REG_ROFF:  reg_rdata = {{(64-OFF_W){1'b0}}, rd_idx, {SHIFT{1'b0}}};
            default:   reg_rdata = '0;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[62:ADDR_W], reg_wdata[SHIFT-1:0]};

    assign base_valid = r_q.vld;
    assign ring_base  = r_q.base;
    assign wr_idx     = r_q.widx;

    // R3: write offset untouched while ring disabled
    p_woff_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_WOFF && !r_q.vld) |=> $stable(r_q.widx));

endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 11,
    parameter int WORDS  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          base_valid,
    input  logic [ADDR_W-OFF_W-1:0]       ring_base,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic                          mem_rvalid,
    input  logic [63:0]                   mem_rdata,
    input  logic                          retire,
    output logic                          mem_req,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          present,
    output logic [KEEP_WORDS-1:0][63:0]   words,
    output logic [IDX_W-1:0]              rd_idx
);
    localparam int WSEL_W = $clog2(WORDS);

    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_HOLD} st_e;

    typedef struct packed {
        st_e                         st;
        logic [WSEL_W-1:0]           wsel;
        logic [KEEP_WORDS-1:0][63:0] words;
        logic [IDX_W-1:0]            ridx;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        case (f_q.st)
            S_IDLE: begin
                if (base_valid && wr_idx != f_q.ridx) begin
                    f_d.st   = S_FETCH;
                    f_d.wsel = '0;
                end
            end
            S_FETCH: begin
                if (mem_rvalid) begin
                    for (int k = 0; k < KEEP_WORDS; k++) begin
                        if (f_q.wsel == WSEL_W'(k)) f_d.words[k] = mem_rdata;
                    end
                    if (f_q.wsel == WSEL_W'(WORDS-1)) f_d.st = S_HOLD;
                    else                              f_d.wsel = f_q.wsel + 1'b1;
                end
            end
            S_HOLD: begin
                if (retire) begin
                    f_d.ridx = f_q.ridx + 1'b1;
                    f_d.st   = S_IDLE;
                end
            end
            default: f_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign mem_req  = (f_q.st == S_FETCH);
    assign mem_addr = {ring_base, f_q.ridx, f_q.wsel, 3'b000};
    assign present  = (f_q.st == S_HOLD);
    assign words    = f_q.words;
    assign rd_idx   = f_q.ridx;

    // R4: a pending read keeps its address until answered
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R8: read pointer only ever steps by one entry (modulo ring size)
    p_rd_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(f_q.ridx) |-> (f_q.ridx == $past(f_q.ridx) + 1'b1));

    // R9: no fetch starts from idle while disabled
    p_no_fetch_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == S_IDLE && !base_valid) |=> !mem_req);

endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
(
    input  logic [KEEP_WORDS-1:0][63:0] words,
    output cmd_fields_t                 fields,
    output logic                        known
);
    always_comb begin
        fields.opcode     = words[0][7:0];
        fields.dev_id     = words[0][63:32];
        fields.event_id   = words[1][31:0];
        fields.phys_id    = words[1][63:32];
        fields.id_bits    = words[1][4:0];
        fields.table_addr = {words[2][47:8], 8'h00};
        fields.map_valid  = words[2][63];
        fields.target     = {words[2][47:16], 16'h0000};
        fields.coll_id    = words[2][15:0];
        known             = op_known(words[0][7:0]);
    end

    logic unused_dec;
    assign unused_dec = ^{words[0][31:8], words[2][62:48]};

endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
    import cmdq_pkg::*;
#(
    parameter int RING_BYTES  = 65536,
    parameter int ENTRY_BYTES = 32,
    parameter int ADDR_W      = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        mem_req,
    output logic [47:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [63:0] mem_rdata,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic        cmd_err,
    output logic [7:0]  cmd_opcode,
    output logic [31:0] cmd_dev_id,
    output logic [31:0] cmd_event_id,
    output logic [31:0] cmd_phys_id,
    output logic [4:0]  cmd_id_bits,
    output logic [47:0] cmd_table_addr,
    output logic        cmd_map_valid,
    output logic [47:0] cmd_target,
    output logic [15:0] cmd_coll_id
);
    localparam int OFF_W       = $clog2(RING_BYTES);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int IDX_W       = OFF_W - ENTRY_SHIFT;
    localparam int WORDS       = ENTRY_BYTES / 8;

    logic                        base_valid;
    logic [ADDR_W-OFF_W-1:0]     ring_base;
    logic [IDX_W-1:0]            wr_idx;
    logic [IDX_W-1:0]            rd_idx;
    logic                        present;
    logic                        known;
    logic                        retire;
    logic [KEEP_WORDS-1:0][63:0] words;
    cmd_fields_t                 fields;

    cmdq_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .rd_idx     (rd_idx),
        .base_valid (base_valid),
        .ring_base  (ring_base),
        .wr_idx     (wr_idx),
        .reg_rdata  (reg_rdata)
    );

    cmdq_fetch #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WORDS(WORDS)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_valid (base_valid),
        .ring_base  (ring_base),
        .wr_idx     (wr_idx),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .retire     (retire),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .present    (present),
        .words      (words),
        .rd_idx     (rd_idx)
    );

    cmdq_decode u_decode (
        .words  (words),
        .fields (fields),
        .known  (known)
    );

    assign cmd_valid      = present && known;
    assign cmd_err        = present && !known;
    assign retire         = cmd_err || (cmd_valid && cmd_ready);

    assign cmd_opcode     = fields.opcode;
    assign cmd_dev_id     = fields.dev_id;
    assign cmd_event_id   = fields.event_id;
    assign cmd_phys_id    = fields.phys_id;
    assign cmd_id_bits    = fields.id_bits;
    assign cmd_table_addr = fields.table_addr;
    assign cmd_map_valid  = fields.map_valid;
    assign cmd_target     = fields.target;
    assign cmd_coll_id    = fields.coll_id;

    // R6: offered command held steady until taken
    p_hold_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode)
                                       && $stable(cmd_dev_id) && $stable(cmd_coll_id)));

    // R6: read offset moves only after an acceptance or a skip
    p_rd_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_idx) |-> ($past(cmd_valid && cmd_ready) || $past(cmd_err)));

    // R7: an unsupported entry is stepped over on the next edge
    p_err_skips_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> (rd_idx == $past(rd_idx) + 1'b1));

endmodule

// File: tb/cmdq_engine_bench.sv
`timescale 1ns/1ps
module cmdq_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_req;
    logic [47:0] mem_addr;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic        cmd_err;
    logic [7:0]  cmd_opcode;
    logic [31:0] cmd_dev_id, cmd_event_id, cmd_phys_id;
    logic [4:0]  cmd_id_bits;
    logic [47:0] cmd_table_addr, cmd_target;
    logic        cmd_map_valid;
    logic [15:0] cmd_coll_id;

    always #2 clk = ~clk;

    cmdq_engine u_cmdq_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_err(cmd_err),
        .cmd_opcode(cmd_opcode), .cmd_dev_id(cmd_dev_id), .cmd_event_id(cmd_event_id),
        .cmd_phys_id(cmd_phys_id), .cmd_id_bits(cmd_id_bits),
        .cmd_table_addr(cmd_table_addr), .cmd_map_valid(cmd_map_valid),
        .cmd_target(cmd_target), .cmd_coll_id(cmd_coll_id)
    );

    // Memory model: 16 entry slots aliased over the ring, word 3 is filler
    localparam logic [31:0] RING_HI = 32'h1234_5678;
    logic [63:0] mem_w [0:15][0:2];
    logic        stall_en = 1'b0;
    logic        stall_ph = 1'b0;
    always @(posedge clk) stall_ph <= ~stall_ph;
    assign mem_rvalid = mem_req && !(stall_en && stall_ph);
    always_comb begin
        if (mem_addr[4:3] == 2'd3) mem_rdata = 64'hF0F0_F0F0_F0F0_F0F0;
        else                       mem_rdata = mem_w[mem_addr[8:5]][mem_addr[4:3]];
    end

    // Address monitor for R4 and R8
    int   addr_bad = 0;
    int   order_bad = 0;
    logic [1:0] exp_word = 2'd0;
    bit   seen_last = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_addr[47:16] != RING_HI || mem_addr[2:0] != 3'd0) addr_bad++;
            if (mem_addr[4:3] != exp_word) order_bad++;
            if (mem_addr[15:5] == 11'h7FF) seen_last = 1'b1;
            if (mem_rvalid) exp_word <= exp_word + 2'd1;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_present(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (cmd_valid || cmd_err) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    function automatic bit exp_known(input logic [7:0] op);
        return op inside {8'h01, 8'h03, 8'h04, 8'h05, 8'h08, 8'h09,
                          8'h0A, 8'h0C, 8'h0D, 8'h0E, 8'h0F};
    endfunction

    // R5 field extraction written from the requirement text
    function automatic logic [221:0] exp_fields(input logic [63:0] w0, w1, w2);
        return {w0[7:0], w0[63:32], w1[31:0], w1[63:32], w1[4:0],
                w2[47:8], 8'h00, w2[63], w2[47:16], 16'h0000, w2[15:0]};
    endfunction

    // Vector table: {stall, word2, word1, word0}
    localparam logic [192:0] VECS [0:7] = '{
        {1'b0, 64'h8000_ABCD_EF01_2300, 64'h0000_0000_0000_0013, 64'h1234_5678_0000_0008},
        {1'b0, 64'h8000_1122_3344_0007, 64'h0000_0000_0000_0000, 64'h0000_00AA_0000_0009},
        {1'b1, 64'h0000_0000_0000_0003, 64'h0000_2001_0000_0042, 64'hDEAD_BEEF_0000_000A},
        {1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0002},
        {1'b1, 64'h7FFF_0000_0000_FFFF, 64'h0000_0000_0000_0011, 64'h0000_0005_0000_000F},
        {1'b0, 64'h0000_0000_1000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005},
        {1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0010},
        {1'b1, 64'h0000_5555_0000_0001, 64'h0000_0000_8000_0000, 64'hFFFF_0000_0000_000E}
    };

    logic [63:0] rv;
    bit          ok;
    logic [63:0] w0, w1, w2;

    initial begin
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 3; w++) mem_w[s][w] = 64'h0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(8'h80, rv); chk(rv == 64'h0, "R1 base", rv, 0);
        reg_read(8'h88, rv); chk(rv == 64'h0, "R1 woff", rv, 0);
        reg_read(8'h90, rv); chk(rv == 64'h0, "R1 roff", rv, 0);
        chk(!mem_req && !cmd_valid && !cmd_err, "R1 outputs idle",
            {mem_req, cmd_valid, cmd_err}, 0);

        // R3: write offset ignored while disabled; R9: nothing fetched
        reg_write(8'h88, 64'h40);
        reg_read(8'h88, rv); chk(rv == 64'h0, "R3 woff ignored", rv, 0);
        repeat (4) @(negedge clk);
        chk(!mem_req, "R9 no fetch when disabled", mem_req, 0);

        // R2 register map
        reg_write(8'h80, {1'b1, 15'h7FFF, RING_HI, 16'hFFFF});
        reg_read(8'h80, rv);
        chk(rv == {1'b1, 15'h0, RING_HI, 16'h0}, "R2 base readback", rv, {1'b1, 15'h0, RING_HI, 16'h0});
        reg_read(8'h98, rv); chk(rv == 64'h0, "R2 unmapped", rv, 0);
        reg_write(8'h90, 64'h60);
        reg_read(8'h90, rv); chk(rv == 64'h0, "R2 roff read-only", rv, 0);

        // Table walk: R4 R5 R6 R7
        for (int i = 0; i < 8; i++) begin
            w0 = VECS[i][63:0]; w1 = VECS[i][127:64]; w2 = VECS[i][191:128];
            mem_w[i][0] = w0; mem_w[i][1] = w1; mem_w[i][2] = w2;
            stall_en = VECS[i][192];
            reg_write(8'h88, 64'((i + 1) * 32) | 64'h1F);
            reg_read(8'h88, rv); chk(rv == 64'((i + 1) * 32), "R2 woff readback", rv, (i + 1) * 32);
            wait_present(ok);
            chk(ok, "R4 entry fetched", ok, 1);
            if (exp_known(w0[7:0])) begin
                chk(cmd_valid && !cmd_err, "R7 known opcode valid", {cmd_valid, cmd_err}, 2'b10);
                chk({cmd_opcode, cmd_dev_id, cmd_event_id, cmd_phys_id, cmd_id_bits,
                     cmd_table_addr, cmd_map_valid, cmd_target, cmd_coll_id} == exp_fields(w0, w1, w2),
                    "R5 fields",
                    {cmd_opcode, cmd_dev_id, cmd_event_id, cmd_phys_id, cmd_id_bits,
                     cmd_table_addr, cmd_map_valid, cmd_target, cmd_coll_id}, exp_fields(w0, w1, w2));
                reg_read(8'h90, rv); chk(rv == 64'(i * 32), "R6 roff before accept", rv, i * 32);
                repeat (2) @(negedge clk);
                chk(cmd_valid && cmd_opcode == w0[7:0], "R6 held under backpressure", cmd_opcode, w0[7:0]);
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                reg_read(8'h90, rv); chk(rv == 64'((i + 1) * 32), "R6 roff after accept", rv, (i + 1) * 32);
                chk(!cmd_valid, "R6 valid drops", cmd_valid, 0);
            end else begin
                chk(cmd_err && !cmd_valid, "R7 unknown flagged", {cmd_valid, cmd_err}, 2'b01);
                @(negedge clk);
                chk(!cmd_err, "R7 error one cycle", cmd_err, 0);
                reg_read(8'h90, rv); chk(rv == 64'((i + 1) * 32), "R7 entry skipped", rv, (i + 1) * 32);
            end
        end
        stall_en = 1'b0;

        // R9: disable while a command is held
        mem_w[8][0] = 64'h5; mem_w[9][0] = 64'h5;
        reg_write(8'h88, 64'd320);
        wait_present(ok);
        chk(ok && cmd_valid, "R9 entry 8 presented", cmd_valid, 1);
        reg_write(8'h80, {1'b0, 15'h0, RING_HI, 16'h0});
        chk(cmd_valid, "R9 held command survives disable", cmd_valid, 1);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        begin
            bit req_seen = 1'b0;
            for (int n = 0; n < 10; n++) begin
                @(negedge clk);
                if (mem_req) req_seen = 1'b1;
            end
            chk(!req_seen, "R9 no new fetch while disabled", req_seen, 0);
        end
        reg_read(8'h90, rv); chk(rv == 64'd288, "R9 roff after held accept", rv, 288);
        reg_write(8'h80, {1'b1, 15'h0, RING_HI, 16'h0});
        wait_present(ok);
        chk(ok && cmd_valid, "R9 resumes after enable", cmd_valid, 1);
        cmd_ready = 1'b1;
        @(negedge clk);
        reg_read(8'h90, rv); chk(rv == 64'd320, "R9 roff after resume", rv, 320);

        // R8 wrap: run the ring to the last entry, then one more
        for (int s = 0; s < 16; s++) mem_w[s][0] = 64'h5;
        reg_write(8'h88, 64'hFFE0);
        ok = 1'b0;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            reg_read(8'h90, rv);
            if (rv == 64'hFFE0) begin ok = 1'b1; break; end
        end
        chk(ok, "R8 reached last entry", rv, 64'hFFE0);
        reg_write(8'h88, 64'h0);
        ok = 1'b0;
        for (int n = 0; n < 50; n++) begin
            @(negedge clk);
            reg_read(8'h90, rv);
            if (rv == 64'h0) begin ok = 1'b1; break; end
        end
        chk(ok, "R8 wrapped to zero", rv, 0);
        chk(seen_last, "R8 last slot fetched", seen_last, 1);
        cmd_ready = 1'b0;
        repeat (8) @(negedge clk);
        chk(!mem_req && !cmd_valid, "R8 idle after wrap", {mem_req, cmd_valid}, 0);

        chk(addr_bad == 0, "R4 address layout", addr_bad, 0);
        chk(order_bad == 0, "R4 word order", order_bad, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule